// File: doc/BRIEF.md
# Serial Audio Clock and Frame-Sync Generator

This block produces the timing for a synchronous serial audio port. A one-cycle reference enable feeds it. From that enable it builds a bit clock, a master clock, a word-end strobe, a frame-end strobe and a frame sync. Bits are counted into words, and the word length is picked from eight fixed sizes. Words are then counted into frames of 1 to 32 words.

The bit clock and the frame sync can each come from the internal dividers or from an external pin. An external pin passes through a two-stage synchronizer and an edge detector before it is used. An external frame sync realigns the counters to the last bit of the frame. The master clock toggles on every reference tick, so each frame holds a whole number of master-clock periods. It is driven only when both clocks are generated internally and the master-clock enable is set. An error flag marks divider settings that would let the bit clock run faster than one fifth of the system clock.

Top module: `afc_top`

## Requirements
- R1: `wl_sel` chooses the bits per word: 0→8, 1→10, 2→12, 3→16, 4→18, 5→20, 6→22, 7→24.
- R2: With the internal bit clock selected, `bclk_o` is a 50 % duty square wave. Its period is 2·D reference ticks, where D is `bclk_div`, and a value of 0 is treated as 1. `bclk_o` resets low.
- R3: A bit ends on each falling edge of the selected bit clock. `word_end` is a one-cycle pulse that follows the end of the last bit of each word. Successive pulses are one word length of bit periods apart.
- R4: A frame holds `frame_words_m1`+1 words (1 to 32). `frame_end` is a one-cycle pulse that comes together with the `word_end` of the last word of the frame.
- R5: With the internal frame sync selected, `fs_o` is high for exactly one bit period, during the last bit of the last word, and it is low while `frame_end` is high.
- R6: With `bclk_ext_sel`=1, `bclk_o` follows `ext_bclk` through two flip-flops, and each falling edge of `ext_bclk` ends one bit.
- R7: With `fs_ext_sel`=1, `fs_o` follows `ext_fs` through two flip-flops. A rising edge of `ext_fs` moves the counters to the last bit of the frame, so `frame_end` follows after the next bit end.
- R8: `mclk_o` toggles on every reference tick only while `mclk_en`=1 and both clocks are internal; otherwise it stays low. A frame therefore holds D·wordlength·words master-clock periods.
- R9: `div_err` is 1 exactly when the internal bit clock is selected and 2·D is below `MIN_RATIO` (default 5).
- R10: While `rst` is high, `bclk_o`, `mclk_o`, `word_end` and `frame_end` are low, and the counters restart at bit 0 of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ce | input | 1 | Reference clock enable, one tick per cycle high |
| bclk_div | input | DIV_W | Bit-clock half-period in reference ticks (0 acts as 1) |
| wl_sel | input | 3 | Word length code |
| frame_words_m1 | input | $clog2(MAX_WORDS) | Words per frame minus one |
| bclk_ext_sel | input | 1 | 1: take the bit clock from `ext_bclk` |
| fs_ext_sel | input | 1 | 1: take the frame sync from `ext_fs` |
| mclk_en | input | 1 | Master clock output enable |
| ext_bclk | input | 1 | External bit clock pin |
| ext_fs | input | 1 | External frame sync pin |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| mclk_o | output | 1 | Master clock |
| word_end | output | 1 | End-of-word strobe |
| frame_end | output | 1 | End-of-frame strobe |
| div_err | output | 1 | Divider setting breaks the bit-clock limit |

## Verification
A corrupted bit or word counter changes the spacing of `word_end` or `frame_end` within one frame. It also changes the count of `fs_o`-high cycles, so the bench measures both spacings and the `fs_o` width over whole frames. A prescaler fault shows within one bit period as a wrong `bclk_o` high time, or a wrong number of master-clock rising edges per frame. Synchronizer and realignment faults show within a few cycles of an external edge, as a missing or late `frame_end`.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int BIT_IDX_W = 5;
    localparam int MAX_WL    = 24;

    typedef enum logic [2:0] {
        WL_8  = 3'd0,
        WL_10 = 3'd1,
        WL_12 = 3'd2,
        WL_16 = 3'd3,
        WL_18 = 3'd4,
        WL_20 = 3'd5,
        WL_22 = 3'd6,
        WL_24 = 3'd7
    } wl_code_e;

    // Level and event pulses of one synchronized pin
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_evt_t;

    function automatic logic [BIT_IDX_W-1:0] wl_bits(input logic [2:0] code);
        logic [BIT_IDX_W-1:0] n;
        case (wl_code_e'(code))
            WL_8:    n = 5'd8;
            WL_10:   n = 5'd10;
            WL_12:   n = 5'd12;
            WL_16:   n = 5'd16;
            WL_18:   n = 5'd18;
            WL_20:   n = 5'd20;
            WL_22:   n = 5'd22;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/afc_edge_sync.sv
module afc_edge_sync
    import afc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output pin_evt_t evt
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb begin
        evt.level = s2;
        evt.rise  = s2 & ~s3;
        evt.fall  = ~s2 & s3;
    end

    assert_rise_single_R6: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> !evt.rise);
    assert_fall_single_R6: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> !evt.fall);

endmodule

// File: rtl/afc_prescaler.sv
module afc_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ref_ce,
    input  logic [DIV_W-1:0] div_lim,
    output logic             bclk,
    output logic             bit_adv
);
    logic [DIV_W-1:0] cnt;
    logic             last;

    assign last = (cnt >= div_lim - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (ref_ce) begin
            if (last) begin
                cnt  <= '0;
                bclk <= ~bclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign bit_adv = en && ref_ce && last && bclk;

    assert_toggle_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (bclk != $past(bclk)) |-> ($past(ref_ce) || !$past(en)));
    assert_adv_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        bit_adv |=> !bclk);

endmodule

// File: rtl/afc_frame_counter.sv
module afc_frame_counter
    import afc_pkg::*;
#(
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_adv,
    input  logic              realign,
    input  logic [2:0]        wl_sel,
    input  logic [WORD_W-1:0] words_m1,
    output logic              word_end,
    output logic              frame_end,
    output logic              fs_int
);
    logic [BIT_IDX_W-1:0] wl;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [WORD_W-1:0]    word_idx;
    logic                 last_bit, last_word;

    assign wl        = wl_bits(wl_sel);
    assign last_bit  = (bit_idx >= wl - 1'b1);
    assign last_word = (word_idx >= words_m1);
    assign fs_int    = last_bit && last_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx   <= '0;
            word_idx  <= '0;
            word_end  <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            word_end  <= 1'b0;
            frame_end <= 1'b0;
            if (realign) begin
                bit_idx  <= wl - 1'b1;
                word_idx <= words_m1;
            end else if (bit_adv) begin
                if (last_bit) begin
                    bit_idx  <= '0;
                    word_end <= 1'b1;
                    if (last_word) begin
                        word_idx  <= '0;
                        frame_end <= 1'b1;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                    end
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    assert_bit_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
        bit_idx < BIT_IDX_W'(MAX_WL));
    assert_word_end_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        word_end |=> !word_end);
    assert_frame_in_word_R4: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> word_end);
    assert_fs_low_at_frame_end_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> !fs_int);

endmodule

// File: rtl/afc_top.sv
module afc_top
    import afc_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int MAX_WORDS = 32,
    parameter int MIN_RATIO = 5,
    localparam int WORD_W   = $clog2(MAX_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_ce,
    input  logic [DIV_W-1:0]  bclk_div,
    input  logic [2:0]        wl_sel,
    input  logic [WORD_W-1:0] frame_words_m1,
    input  logic              bclk_ext_sel,
    input  logic              fs_ext_sel,
    input  logic              mclk_en,
    input  logic              ext_bclk,
    input  logic              ext_fs,
    output logic              bclk_o,
    output logic              fs_o,
    output logic              mclk_o,
    output logic              word_end,
    output logic              frame_end,
    output logic              div_err
);
    localparam int N_PINS = 2;
    localparam int P_BCLK = 0;
    localparam int P_FS   = 1;

    logic [N_PINS-1:0] pins;
    pin_evt_t          evt [N_PINS];

    assign pins[P_BCLK] = ext_bclk;
    assign pins[P_FS]   = ext_fs;

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        afc_edge_sync u_sync (
            .clk (clk),
            .rst (rst),
            .pin (pins[g]),
            .evt (evt[g])
        );
    end

    logic [DIV_W-1:0] div_eff;
    logic             int_bclk, int_adv, bit_adv, fs_int, mclk_run;

    assign div_eff = (bclk_div == '0) ? DIV_W'(1) : bclk_div;

    afc_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (!bclk_ext_sel),
        .ref_ce  (ref_ce),
        .div_lim (div_eff),
        .bclk    (int_bclk),
        .bit_adv (int_adv)
    );

    assign bit_adv = bclk_ext_sel ? evt[P_BCLK].fall : int_adv;

    afc_frame_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .bit_adv   (bit_adv),
        .realign   (fs_ext_sel && evt[P_FS].rise),
        .wl_sel    (wl_sel),
        .words_m1  (frame_words_m1),
        .word_end  (word_end),
        .frame_end (frame_end),
        .fs_int    (fs_int)
    );

    assign bclk_o = bclk_ext_sel ? evt[P_BCLK].level : int_bclk;
    assign fs_o   = fs_ext_sel   ? evt[P_FS].level   : fs_int;

    assign mclk_run = mclk_en && !bclk_ext_sel && !fs_ext_sel;

    always_ff @(posedge clk) begin
        if (rst || !mclk_run) begin
            mclk_o <= 1'b0;
        end else if (ref_ce) begin
            mclk_o <= ~mclk_o;
        end
    end

    assign div_err = !bclk_ext_sel && ((32'(div_eff) * 2) < MIN_RATIO);

    assert_mclk_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !mclk_run |=> !mclk_o);
    assert_mclk_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (mclk_o != $past(mclk_o)) |-> ($past(ref_ce) || !$past(mclk_run)));
    assert_no_err_external_R9: assert property (@(posedge clk) disable iff (rst)
        bclk_ext_sel |-> !div_err);
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!word_end && !frame_end && !mclk_o));

endmodule

// File: tb/afc_top_tb_top.sv
module afc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_ce = 1'b1;
    logic [7:0] bclk_div = 8'd3;
    logic [2:0] wl_sel = 3'd0;
    logic [4:0] frame_words_m1 = 5'd1;
    logic       bclk_ext_sel = 1'b0, fs_ext_sel = 1'b0, mclk_en = 1'b1;
    logic       ext_bclk = 1'b0, ext_fs = 1'b0;
    logic       bclk_o, fs_o, mclk_o, word_end, frame_end, div_err;

    int total = 0, bad = 0;
    bit ce_half = 0, ce_ph = 0, ext_run = 0;
    int ext_cnt = 0;

    always #2.5 clk = ~clk;

    afc_top dut_i (
        .clk(clk), .rst(rst), .ref_ce(ref_ce), .bclk_div(bclk_div),
        .wl_sel(wl_sel), .frame_words_m1(frame_words_m1),
        .bclk_ext_sel(bclk_ext_sel), .fs_ext_sel(fs_ext_sel), .mclk_en(mclk_en),
        .ext_bclk(ext_bclk), .ext_fs(ext_fs), .bclk_o(bclk_o), .fs_o(fs_o),
        .mclk_o(mclk_o), .word_end(word_end), .frame_end(frame_end), .div_err(div_err)
    );

    // Background stimulus, driven on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            ce_ph = ~ce_ph;
            ref_ce = ce_half ? ce_ph : 1'b1;
            if (ext_run) begin
                ext_cnt++;
                if (ext_cnt % 4 == 0) ext_bclk = ~ext_bclk;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: act=timeout exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Measures one whole frame between two frame_end pulses
    task automatic measure(output int flen, output int words, output int wlen,
                           output int fs_hi, output int bclk_hi, output int mclk_r);
        int guard = 0;
        bit prev_m;
        flen = -1; words = 0; wlen = -1; fs_hi = 0; bclk_hi = 0; mclk_r = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!frame_end && guard < 8000);
        if (!frame_end) return;
        prev_m = mclk_o;
        for (int k = 1; k < 8000; k++) begin
            @(negedge clk);
            if (word_end) begin
                words++;
                if (wlen < 0) wlen = k;
            end
            if (fs_o) fs_hi++;
            if (bclk_o) bclk_hi++;
            if (mclk_o && !prev_m) mclk_r++;
            prev_m = mclk_o;
            if (frame_end) begin
                flen = k;
                break;
            end
        end
    endtask

    // div, wl code, words-1, expected bits per word
    localparam int NV = 9;
    localparam int VEC [NV][4] = '{
        '{3, 0, 1, 8},  '{4, 3, 0, 16}, '{3, 7, 2, 24},
        '{5, 1, 1, 10}, '{3, 2, 0, 12}, '{3, 4, 0, 18},
        '{3, 5, 0, 20}, '{3, 6, 0, 22}, '{3, 0, 31, 8}
    };

    initial begin
        int fl, nw, wln, fh, bh, mr, d, wl, w;
        // R10 reset state
        repeat (2) @(negedge clk);
        check("R10 bclk", bclk_o, 0);
        check("R10 word_end", word_end, 0);
        check("R10 frame_end", frame_end, 0);
        check("R10 mclk", mclk_o, 0);
        check("R10 fs", fs_o, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            d = VEC[v][0]; wl = VEC[v][3]; w = VEC[v][2] + 1;
            bclk_div = 8'(VEC[v][0]);
            wl_sel = 3'(VEC[v][1]);
            frame_words_m1 = 5'(VEC[v][2]);
            do_reset();
            measure(fl, nw, wln, fh, bh, mr);
            check("R4 frame length", fl, 2 * d * wl * w);
            check("R4 words per frame", nw, w);
            check("R1 R3 word spacing", wln, 2 * d * wl);
            check("R5 fs width", fh, 2 * d);
            check("R2 bclk high time", bh, d * wl * w);
            check("R8 mclk per frame", mr, d * wl * w);
            check("R9 no error", div_err, 0);
        end

        // R9 limit and R2 zero divider
        bclk_div = 8'd2; #1 check("R9 div2 flagged", div_err, 1);
        bclk_div = 8'd0; wl_sel = 3'd0; frame_words_m1 = 5'd0;
        #1 check("R9 div0 flagged", div_err, 1);
        do_reset();
        measure(fl, nw, wln, fh, bh, mr);
        check("R2 div0 acts as 1", fl, 16);

        // R8 half-rate reference ticks, then master clock disabled
        bclk_div = 8'd3; frame_words_m1 = 5'd1; ce_half = 1;
        do_reset();
        measure(fl, nw, wln, fh, bh, mr);
        check("R2 half-rate frame", fl, 192);
        check("R8 half-rate mclk", mr, 48);
        ce_half = 0; mclk_en = 1'b0;
        do_reset();
        measure(fl, nw, wln, fh, bh, mr);
        check("R8 mclk disabled", mr, 0);
        mclk_en = 1'b1;

        // R6 external bit clock, period 8 cycles
        bclk_ext_sel = 1'b1; bclk_div = 8'd1;
        #1 check("R9 external no error", div_err, 0);
        ext_run = 1;
        do_reset();
        measure(fl, nw, wln, fh, bh, mr);
        check("R6 ext word spacing", wln, 64);
        check("R6 ext frame length", fl, 128);
        check("R6 ext bclk high", bh, 64);
        check("R8 mclk off with ext bclk", mr, 0);
        ext_run = 0; bclk_ext_sel = 1'b0; bclk_div = 8'd3;

        // R7 external frame sync realigns
        fs_ext_sel = 1'b1; frame_words_m1 = 5'd3;
        do_reset();
        repeat (210) @(negedge clk);
        begin
            int lat = -1;
            ext_fs = 1'b1;
            for (int k = 1; k <= 15; k++) begin
                @(negedge clk);
                if (k == 3) check("R7 fs follows pin", fs_o, 1);
                if (frame_end && lat < 0) lat = k;
            end
            check("R7 realign frame_end", (lat > 0 && lat <= 12) ? 1 : 0, 1);
            ext_fs = 1'b0;
            repeat (3) @(negedge clk);
            check("R7 fs follows low", fs_o, 0);
        end
        fs_ext_sel = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule